// File: doc/BRIEF.md
# Byte-Addressed Serial Port with Gated Baud Divisor

This block is a memory-mapped asynchronous serial port. Software talks to it through a byte-wide register bus with a 3-bit offset. It can load a transmit holding register, fetch the last received byte, set a line-control byte, poll a line-status byte, and program a 16-bit baud divisor. Bit 7 of the line-control byte is the divisor access bit. While it is set, offsets 0 and 1 reach the divisor's low and high bytes. While it is clear, offset 0 is the data port and offset 1 reads as zero.

An internal divider counts peripheral clock cycles and emits one oversampling tick every D cycles, where D is the divisor. The serial bit rate is therefore f_clk / (16 × D). For example, D = 194 on a 30 MHz clock gives about 9.66 kbaud. The ticks pace a transmitter that sends one start bit, eight data bits LSB first and one stop bit. The same ticks pace a receiver that oversamples the line by 16.

Software keeps both directions moving by polling status bits. It writes a byte only when the holding-empty bit reads 1. It reads a byte when the data-ready bit reads 1. Reads return the addressed register combinationally in the same cycle, and a read of the data port takes effect on the clock edge it is sampled on.

Top module: `uart_regif`

## Requirements
- R1: After reset the status byte at offset 5 reads 0x60, the control byte at offset 3 reads 0x00, the divisor is 0x0001 and `txd` is high.
- R2: Offset 3 is a read/write control byte. When its bit 7 is 1, a write to offset 0 loads divisor bits 7:0 and a write to offset 1 loads divisor bits 15:8, and reads of those offsets return the same bytes.
- R3: When control bit 7 is 0, a write to offset 0 queues a byte for transmission and leaves the divisor unchanged, and a read of offset 0 returns the last received byte.
- R4: The oversampling tick repeats every D clock cycles. A divisor of 0 stops the tick, so no frame starts and `txd` holds its level.
- R5: A transmitted frame is a low start bit, then eight data bits LSB first, then a high stop bit. Each bit lasts 16 ticks, and a frame begins on a tick.
- R6: Status bit 5 is 1 while the holding register is empty, and a data write made while it is 0 is dropped. Status bit 6 is 1 only when the holding register is empty and no frame is on the line.
- R7: The receiver starts on a falling edge of the synchronised `rxd` and re-samples on the 8th tick. If the line is high again by then, it returns to idle and delivers no byte.
- R8: After a confirmed start, each data bit is sampled every 16 ticks, LSB first, followed by the stop bit. A high stop bit stores the byte and sets status bit 0. A low stop bit discards the byte.
- R9: A read of offset 0 with control bit 7 clear clears status bit 0, unless a new byte arrives in the same cycle. A new byte overwrites an unread one.
- R10: Offset 1 reads 0 while control bit 7 is clear, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed offset |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |

## Verification
The bench first attacks the access bit. A decode that ignores it would either corrupt the divisor on a data write, or send a byte when software meant to load the divisor. It writes a second and third byte while a frame is in flight. A port that overwrites a full holding register sends the third byte, and a port that keeps status bit 5 set too long loses the second. A zero divisor must freeze the transmitter and leave the byte waiting. A short low glitch and a frame with a low stop bit must both leave status bit 0 clear. A receiver that skipped the mid-start confirmation, or the stop check, would deliver a bogus byte.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_DIVHI = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_LCTL  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_LSTAT = 3'd5;

  localparam int ACCESS_BIT = 7;
  localparam int STAT_RDY   = 0;
  localparam int STAT_THRE  = 5;
  localparam int STAT_IDLE  = 6;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (divisor == '0) begin
        cnt_q <= '0;
      end else if (cnt_q >= divisor - DIV_W'(1)) begin
        cnt_q <= '0;
        tick  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hold_empty,
  output logic              line_idle,
  output logic              txd
);
  localparam int CNT_W   = $clog2(OVS);
  localparam int FRAME_W = DATA_W + 2;
  localparam int BIT_W   = $clog2(FRAME_W);

  logic [DATA_W-1:0]  hold_q;
  logic               hold_full_q;
  logic [FRAME_W-1:0] frame_q;
  logic               busy_q;
  logic [CNT_W-1:0]   tcnt_q;
  logic [BIT_W-1:0]   bcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      frame_q     <= '1;
      busy_q      <= 1'b0;
      tcnt_q      <= '0;
      bcnt_q      <= '0;
    end else begin
      if (wr_en && !hold_full_q) begin
        hold_q      <= wr_data;
        hold_full_q <= 1'b1;
      end
      if (tick) begin
        if (busy_q) begin
          if (tcnt_q == CNT_W'(OVS - 1)) begin
            tcnt_q  <= '0;
            frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
            if (bcnt_q == BIT_W'(FRAME_W - 1)) begin
              busy_q <= 1'b0;
              bcnt_q <= '0;
            end else begin
              bcnt_q <= bcnt_q + BIT_W'(1);
            end
          end else begin
            tcnt_q <= tcnt_q + CNT_W'(1);
          end
        end else if (hold_full_q) begin
          frame_q     <= {1'b1, hold_q, 1'b0};
          busy_q      <= 1'b1;
          tcnt_q      <= '0;
          bcnt_q      <= '0;
          hold_full_q <= 1'b0;
        end
      end
    end
  end

  assign hold_empty = !hold_full_q;
  assign line_idle  = !hold_full_q && !busy_q;
  assign txd        = frame_q[0];
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
  import uart_regif_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_new
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W);

  logic [1:0]        sync_q;
  logic              prev_q;
  rx_state_e         state_q;
  logic [CNT_W-1:0]  tcnt_q;
  logic [BIT_W-1:0]  bcnt_q;
  logic [DATA_W-1:0] shift_q;
  logic              line_s;

  assign line_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      prev_q  <= 1'b1;
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      shift_q <= '0;
      rx_data <= '0;
      rx_new  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd};
      prev_q <= line_s;
      rx_new <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          if (prev_q && !line_s) begin
            state_q <= RX_START;
            tcnt_q  <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (tcnt_q == CNT_W'(OVS / 2 - 1)) begin
              tcnt_q <= '0;
              bcnt_q <= '0;
              state_q <= line_s ? RX_IDLE : RX_DATA;
            end else begin
              tcnt_q <= tcnt_q + CNT_W'(1);
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (tcnt_q == CNT_W'(OVS - 1)) begin
              tcnt_q  <= '0;
              shift_q <= {line_s, shift_q[DATA_W-1:1]};
              if (bcnt_q == BIT_W'(DATA_W - 1)) begin
                state_q <= RX_STOP;
              end else begin
                bcnt_q <= bcnt_q + BIT_W'(1);
              end
            end else begin
              tcnt_q <= tcnt_q + CNT_W'(1);
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (tcnt_q == CNT_W'(OVS - 1)) begin
              tcnt_q  <= '0;
              state_q <= RX_IDLE;
              if (line_s) begin
                rx_data <= shift_q;
                rx_new  <= 1'b1;
              end
            end else begin
              tcnt_q <= tcnt_q + CNT_W'(1);
            end
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int          REG_W     = 8,
  parameter int          OVS       = 16,
  parameter int unsigned DIV_RESET = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             rxd,
  output logic             txd
);
  localparam int DIV_W = 2 * REG_W;

  logic [REG_W-1:0] lcr_q;
  logic [DIV_W-1:0] div_q;
  logic             rdy_q;
  logic             dlab;
  logic             baud_tick;
  logic             thr_wr;
  logic             rbr_rd;
  logic             tx_hold_empty;
  logic             tx_idle;
  logic [REG_W-1:0] rx_data;
  logic             rx_new;
  logic [REG_W-1:0] lsr;

  assign dlab   = lcr_q[ACCESS_BIT];
  assign thr_wr = bus_wr && (bus_addr == OFS_DATA) && !dlab;
  assign rbr_rd = bus_rd && (bus_addr == OFS_DATA) && !dlab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q <= '0;
      div_q <= DIV_W'(DIV_RESET);
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_DATA:  if (dlab) div_q[REG_W-1:0]     <= bus_wdata;
        OFS_DIVHI: if (dlab) div_q[DIV_W-1:REG_W] <= bus_wdata;
        OFS_LCTL:  lcr_q <= bus_wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdy_q <= 1'b0;
    else if (rx_new) rdy_q <= 1'b1;
    else if (rbr_rd) rdy_q <= 1'b0;
  end

  always_comb begin
    lsr            = '0;
    lsr[STAT_RDY]  = rdy_q;
    lsr[STAT_THRE] = tx_hold_empty;
    lsr[STAT_IDLE] = tx_idle;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_DATA:  bus_rdata = dlab ? div_q[REG_W-1:0] : rx_data;
      OFS_DIVHI: bus_rdata = dlab ? div_q[DIV_W-1:REG_W] : '0;
      OFS_LCTL:  bus_rdata = lcr_q;
      OFS_LSTAT: bus_rdata = lsr;
      default:   bus_rdata = '0;
    endcase
  end

  uart_baud_gen #(.DIV_W(DIV_W)) i_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .divisor (div_q),
    .tick    (baud_tick)
  );

  uart_tx_path #(.DATA_W(REG_W), .OVS(OVS)) i_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (baud_tick),
    .wr_en      (thr_wr),
    .wr_data    (bus_wdata),
    .hold_empty (tx_hold_empty),
    .line_idle  (tx_idle),
    .txd        (txd)
  );

  uart_rx_path #(.DATA_W(REG_W), .OVS(OVS)) i_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .rxd     (rxd),
    .rx_data (rx_data),
    .rx_new  (rx_new)
  );
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk
  import uart_regif_pkg::*;
#(
  parameter int REG_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [REG_W-1:0]   bus_wdata,
  input logic               txd,
  input logic [REG_W-1:0]   lcr_q,
  input logic [2*REG_W-1:0] div_q,
  input logic               rdy_q,
  input logic               rx_new,
  input logic               tx_hold_empty,
  input logic               tx_idle
);
  // R2
  lctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_LCTL) |=> (lcr_q == $past(bus_wdata)));

  // R3
  div_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DATA && !lcr_q[ACCESS_BIT]) |=> $stable(div_q));

  // R4
  zero_div_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div_q) == '0) |=> $stable(txd));

  // R5
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> txd);

  // R6
  idle_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> tx_hold_empty);

  // R8
  new_byte_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_new |=> rdy_q);

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_DATA && !lcr_q[ACCESS_BIT] && !rx_new) |=> !rdy_q);
endmodule

bind uart_regif uart_regif_chk #(.REG_W(REG_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_wdata     (bus_wdata),
  .txd           (txd),
  .lcr_q         (lcr_q),
  .div_q         (div_q),
  .rdy_q         (rdy_q),
  .rx_new        (rx_new),
  .tx_hold_empty (tx_hold_empty),
  .tx_idle       (tx_idle)
);

// File: tb/test_uart_regif.sv
module test_uart_regif;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rxd = 1'b1;
  logic       txd;

  always #5 clk = ~clk;

  uart_regif i_uart_regif (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
    .bus_rd (bus_rd), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .rxd (rxd), .txd (txd)
  );

  int checks = 0;
  int errors = 0;
  int bitc = 16;
  logic [7:0] tx_q[$];
  bit         stop_q[$];
  logic [7:0] mon_b;
  bit         mon_stop;
  logic [7:0] rd;

  task automatic chk(string req, logic [31:0] act, logic [31:0 ] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_lsr(bit rdy, bit thre, bit idle);
    return {1'b0, idle, thre, 4'b0000, rdy};
  endfunction

  task automatic bus_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_div(int d);
    bus_write(3'd3, 8'h83);
    bus_write(3'd0, d[7:0]);
    bus_write(3'd1, d[15:8]);
    bus_write(3'd3, 8'h03);
    bitc = 16 * d;
  endtask

  task automatic wait_tx(int n);
    for (int t = 0; t < 40000 && tx_q.size() < n; t++) @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    s = 8'h00;
    for (int t = 0; t < 20000 && s[6] == 1'b0; t++) bus_read(3'd5, s);
    repeat (bitc + 2) @(negedge clk);
  endtask

  task automatic send_rx(logic [7:0] d, bit stopb);
    rxd = 1'b0;
    repeat (bitc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (bitc) @(negedge clk);
    end
    rxd = stopb;
    repeat (bitc) @(negedge clk);
    rxd = 1'b1;
    repeat (bitc) @(negedge clk);
  endtask

  // transmit line monitor: samples each bit at its middle
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0 && bitc > 0) begin
        repeat (bitc / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (bitc) @(negedge clk);
          mon_b[i] = txd;
        end
        repeat (bitc) @(negedge clk);
        mon_stop = txd;
        tx_q.push_back(mon_b);
        stop_q.push_back(mon_stop);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int d;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(3'd5, rd); chk("R1 status", rd, exp_lsr(0, 1, 1));
    bus_read(3'd3, rd); chk("R1 control", rd, 8'h00);
    chk("R1 txd", txd, 1'b1);
    bus_write(3'd3, 8'h80);
    bus_read(3'd0, rd); chk("R1 R2 div low", rd, 8'h01);
    bus_read(3'd1, rd); chk("R1 R2 div high", rd, 8'h00);
    bus_write(3'd3, 8'h00);

    // R10 offsets without access
    bus_read(3'd1, rd); chk("R10 offset1", rd, 8'h00);
    bus_read(3'd2, rd); chk("R10 offset2", rd, 8'h00);
    bus_read(3'd7, rd); chk("R10 offset7", rd, 8'h00);

    // R2 divisor programming
    set_div(2);
    bus_write(3'd3, 8'h80);
    bus_read(3'd0, rd); chk("R2 div low", rd, 8'h02);
    bus_read(3'd3, rd); chk("R2 control", rd, 8'h80);
    bus_write(3'd3, 8'h03);
    bus_read(3'd3, rd); chk("R2 control", rd, 8'h03);

    // R3 data write leaves divisor alone, R5 frame
    bus_write(3'd0, 8'hA5);
    bus_write(3'd3, 8'h80);
    bus_read(3'd0, rd); chk("R3 div kept", rd, 8'h02);
    bus_read(3'd1, rd); chk("R3 div kept high", rd, 8'h00);
    bus_write(3'd3, 8'h03);
    wait_tx(1);
    chk("R5 count", tx_q.size(), 1);
    if (tx_q.size() > 0) begin
      chk("R5 data", tx_q.pop_front(), 8'hA5);
      chk("R5 stop", stop_q.pop_front(), 1'b1);
    end
    wait_idle();
    bus_read(3'd5, rd); chk("R6 idle status", rd, exp_lsr(0, 1, 1));

    // R6 holding register full: third write dropped
    bus_write(3'd0, 8'h11);
    rd = 8'h00;
    for (int t = 0; t < 100 && rd[5] == 1'b0; t++) bus_read(3'd5, rd);
    chk("R6 loaded", rd, exp_lsr(0, 1, 0));
    bus_write(3'd0, 8'h22);
    bus_read(3'd5, rd); chk("R6 full", rd, exp_lsr(0, 0, 0));
    bus_write(3'd0, 8'h33);
    wait_tx(2);
    repeat (bitc * 12) @(negedge clk);
    chk("R6 frames", tx_q.size(), 2);
    if (tx_q.size() >= 2) begin
      chk("R6 first", tx_q.pop_front(), 8'h11);
      chk("R6 second", tx_q.pop_front(), 8'h22);
      void'(stop_q.pop_front()); void'(stop_q.pop_front());
    end
    tx_q.delete(); stop_q.delete();
    wait_idle();

    // R4 zero divisor freezes transmitter
    set_div(0);
    bus_write(3'd0, 8'h5A);
    b = 8'h00;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (txd !== 1'b1) b = 8'h01;
    end
    chk("R4 txd frozen", b, 8'h00);
    bus_read(3'd5, rd); chk("R4 held", rd, exp_lsr(0, 0, 0));
    set_div(3);
    wait_tx(1);
    chk("R4 R5 after resume", tx_q.size(), 1);
    if (tx_q.size() > 0) begin
      chk("R4 R5 data", tx_q.pop_front(), 8'h5A);
      void'(stop_q.pop_front());
    end
    wait_idle();

    // R7 R8 R9 receive
    set_div(2);
    send_rx(8'h3C, 1'b1);
    bus_read(3'd5, rd); chk("R8 ready", rd, exp_lsr(1, 1, 1));
    bus_read(3'd0, rd); chk("R8 data", rd, 8'h3C);
    bus_read(3'd5, rd); chk("R9 cleared", rd, exp_lsr(0, 1, 1));

    rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (bitc * 20) @(negedge clk);
    bus_read(3'd5, rd); chk("R7 glitch", rd, exp_lsr(0, 1, 1));

    send_rx(8'h77, 1'b0);
    bus_read(3'd5, rd); chk("R8 bad stop", rd, exp_lsr(0, 1, 1));

    send_rx(8'h01, 1'b1);
    send_rx(8'h02, 1'b1);
    bus_read(3'd0, rd); chk("R9 overwrite", rd, 8'h02);

    // random mix
    for (int k = 0; k < 8; k++) begin
      d = 1 + int'($urandom_range(2));
      set_div(d);
      b = 8'($urandom);
      bus_write(3'd0, b);
      wait_tx(1);
      if (tx_q.size() > 0) begin
        chk("R5 random tx", tx_q.pop_front(), b);
        chk("R5 random stop", stop_q.pop_front(), 1'b1);
      end else begin
        chk("R5 random tx missing", 0, 1);
      end
      wait_idle();
      b = 8'($urandom);
      send_rx(b, 1'b1);
      bus_read(3'd5, rd); chk("R8 random ready", rd[0], 1'b1);
      bus_read(3'd0, rd); chk("R8 random rx", rd, b);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule